// File: doc/BRIEF.md
# Level-priority interrupt vector resolver

This block chooses which interrupt source a processor is offered. Each of 64 request lines has an 8-bit priority byte. A source takes part only when it is qualified: it must be pending or forced, it must be enabled, and it must not be masked. Among the qualified sources, the one with the largest priority byte wins. When several share the largest byte, the source with the higher index wins. The block presents the winner's priority byte as the interrupt level and the winner's index plus a fixed base as the vector number. When no source qualifies, it presents level zero and a fixed idle vector.

The resolution is purely combinational and is built as a balanced tree of two-way merge cells, so its depth grows with log2 of the source count. A parameter adds a registered copy of the level and the vector, which loads on every rising clock edge. With the parameter cleared, that copy is a straight wire. The surrounding controller owns the pending, force, enable, mask and priority state and feeds it in as flat vectors.

Top module: `irq_vec_resolver`

## Requirements
- R1: Source i is qualified exactly when (pend_i[i] OR force_i[i]) AND en_i[i] AND NOT mask_i[i]. An unqualified source never affects the outputs, whatever its priority.
- R2: Among qualified sources, the one whose priority byte (prio_i[8*i+7:8*i]) is numerically largest wins.
- R3: When qualified sources share the largest priority byte, the one with the highest index wins.
- R4: With a winner at index i, vec_o equals i + 64, so it always lies in the range 64 to 127.
- R5: With a winner, lvl_o equals the winner's full 8-bit priority byte.
- R6: With no qualified source, lvl_o is 0 and vec_o is 24.
- R7: A qualified source whose priority byte is 0 can still win. When it does, lvl_o is 0 and vec_o is its index + 64, not the idle vector.
- R8: lvl_q_o and vec_q_o take the values that lvl_o and vec_o had at the preceding rising clock edge. While rst_n is low they hold level 0 and vector 24.
- R9: lvl_o and vec_o follow input changes within the same cycle, with no clock edge, and are not affected by rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output copy |
| rst_n | input | 1 | Active-low asynchronous reset of the registered copy |
| pend_i | input | 64 | Pending request per source |
| force_i | input | 64 | Software-forced request per source |
| en_i | input | 64 | Per-source enable |
| mask_i | input | 64 | Per-source mask; 1 blocks the source |
| prio_i | input | 512 | Priority bytes; source i at bits 8*i+7 down to 8*i |
| lvl_o | output | 8 | Combinational winning level |
| vec_o | output | 8 | Combinational winning vector |
| lvl_q_o | output | 8 | Registered level |
| vec_q_o | output | 8 | Registered vector |

## Verification
The bench checks several tie cases: all 64 sources at one level, and a subset with equal levels spread over both halves of the tree. A merge cell that used a strict compare would hand the win to the lowest index. The bench also drives qualified sources whose priority is zero. A design that treated level zero as "nothing pending" would return the idle vector 24 instead of index + 64. Further vectors set force without pend, clear one enable bit, and mask the source that would otherwise win. A qualification term that dropped or inverted one input would select the wrong vector in at least one of these. Random patterns are compared against a serial upward scan with greater-or-equal; some have all-equal priorities and some are all zero. The registered copy is checked to lag the combinational result by exactly one edge.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

   localparam int DEF_NUM_SRC  = 64;
   localparam int DEF_PRIO_W   = 8;
   localparam int DEF_VEC_W    = 8;
   localparam int DEF_VEC_BASE = 64;
   localparam int DEF_IDLE_VEC = 24;

   // smallest power of two not below n (n >= 1)
   function automatic int pow2_ceil(input int n);
      int p;
      p = 1;
      for (int k = 0; k < 31; k++) begin
         if (p < n) p = p << 1;
      end
      return p;
   endfunction

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
   parameter int NUM_SRC = 64
) (
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] force_i,
   input  logic [NUM_SRC-1:0] en_i,
   input  logic [NUM_SRC-1:0] mask_i,
   output logic [NUM_SRC-1:0] act_o
);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_bit
      assign act_o[s] = (pend_i[s] | force_i[s]) & en_i[s] & ~mask_i[s];
   end

endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
   parameter int PRIO_W = 8,
   parameter int IDX_W  = 6
) (
   input  logic              lo_vld,
   input  logic [PRIO_W-1:0] lo_pri,
   input  logic [IDX_W-1:0]  lo_idx,
   input  logic              hi_vld,
   input  logic [PRIO_W-1:0] hi_pri,
   input  logic [IDX_W-1:0]  hi_idx,
   output logic              out_vld,
   output logic [PRIO_W-1:0] out_pri,
   output logic [IDX_W-1:0]  out_idx
);

   // the upper-index side wins on equal level
   logic take_hi;

   assign take_hi = hi_vld & (~lo_vld | (hi_pri >= lo_pri));
   assign out_vld = lo_vld | hi_vld;
   assign out_pri = take_hi ? hi_pri : lo_pri;
   assign out_idx = take_hi ? hi_idx : lo_idx;

endmodule

// File: rtl/irq_tree.sv
module irq_tree #(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 8,
   parameter int IDX_W   = 6
) (
   input  logic [NUM_SRC-1:0]        act_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   output logic                      any_o,
   output logic [PRIO_W-1:0]         pri_o,
   output logic [IDX_W-1:0]          idx_o
);

   localparam int LEAVES = 1 << IDX_W;
   localparam int NODES  = 2 * LEAVES - 1;
   localparam int FIRST  = LEAVES - 1;

   if (LEAVES < NUM_SRC) begin : g_bad_idx
      $error("irq_tree: IDX_W too narrow for NUM_SRC");
   end

   // heap layout: node k has children 2k+1 (lower indices) and 2k+2
   logic              nv [NODES];
   logic [PRIO_W-1:0] np [NODES];
   logic [IDX_W-1:0]  ni [NODES];

   for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < NUM_SRC) begin : g_real
         assign nv[FIRST+i] = act_i[i];
         assign np[FIRST+i] = act_i[i] ? prio_i[i*PRIO_W +: PRIO_W] : '0;
      end else begin : g_pad
         assign nv[FIRST+i] = 1'b0;
         assign np[FIRST+i] = '0;
      end
      assign ni[FIRST+i] = IDX_W'(i);
   end

   for (genvar k = 0; k < FIRST; k++) begin : g_node
      irq_merge #(
         .PRIO_W (PRIO_W),
         .IDX_W  (IDX_W)
      ) u_merge (
         .lo_vld  (nv[2*k+1]),
         .lo_pri  (np[2*k+1]),
         .lo_idx  (ni[2*k+1]),
         .hi_vld  (nv[2*k+2]),
         .hi_pri  (np[2*k+2]),
         .hi_idx  (ni[2*k+2]),
         .out_vld (nv[k]),
         .out_pri (np[k]),
         .out_idx (ni[k])
      );
   end

   assign any_o = nv[0];
   assign pri_o = np[0];
   assign idx_o = ni[0];

endmodule

// File: rtl/irq_vec_resolver.sv
module irq_vec_resolver #(
   parameter int NUM_SRC  = irq_res_pkg::DEF_NUM_SRC,
   parameter int PRIO_W   = irq_res_pkg::DEF_PRIO_W,
   parameter int VEC_W    = irq_res_pkg::DEF_VEC_W,
   parameter int VEC_BASE = irq_res_pkg::DEF_VEC_BASE,
   parameter int IDLE_VEC = irq_res_pkg::DEF_IDLE_VEC,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        pend_i,
   input  logic [NUM_SRC-1:0]        force_i,
   input  logic [NUM_SRC-1:0]        en_i,
   input  logic [NUM_SRC-1:0]        mask_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   output logic [PRIO_W-1:0]         lvl_o,
   output logic [VEC_W-1:0]          vec_o,
   output logic [PRIO_W-1:0]         lvl_q_o,
   output logic [VEC_W-1:0]          vec_q_o
);

   localparam int IDX_W = $clog2(irq_res_pkg::pow2_ceil(NUM_SRC));

   if (NUM_SRC < 2) begin : g_bad_num
      $error("irq_vec_resolver: NUM_SRC must be at least 2");
   end
   if (VEC_BASE + NUM_SRC > (1 << VEC_W)) begin : g_bad_base
      $error("irq_vec_resolver: vector range exceeds VEC_W");
   end
   if (IDLE_VEC >= (1 << VEC_W)) begin : g_bad_idle
      $error("irq_vec_resolver: IDLE_VEC exceeds VEC_W");
   end
   if (IDX_W > VEC_W) begin : g_bad_idx
      $error("irq_vec_resolver: index wider than vector");
   end

   logic [NUM_SRC-1:0] act;
   logic               win_any;
   logic [PRIO_W-1:0]  win_pri;
   logic [IDX_W-1:0]   win_idx;

   irq_qualify #(
      .NUM_SRC (NUM_SRC)
   ) u_qual (
      .pend_i  (pend_i),
      .force_i (force_i),
      .en_i    (en_i),
      .mask_i  (mask_i),
      .act_o   (act)
   );

   irq_tree #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .IDX_W   (IDX_W)
   ) u_tree (
      .act_i  (act),
      .prio_i (prio_i),
      .any_o  (win_any),
      .pri_o  (win_pri),
      .idx_o  (win_idx)
   );

   always_comb begin
      if (win_any) begin
         lvl_o = win_pri;
         vec_o = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
      end else begin
         lvl_o = '0;
         vec_o = VEC_W'(IDLE_VEC);
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q_o <= '0;
            vec_q_o <= VEC_W'(IDLE_VEC);
         end else begin
            lvl_q_o <= lvl_o;
            vec_q_o <= vec_o;
         end
      end
   end else begin : g_wire
      assign lvl_q_o = lvl_o;
      assign vec_q_o = vec_o;
   end

endmodule

// File: rtl/irq_res_chk.sv
module irq_res_chk #(
   parameter int NUM_SRC  = 64,
   parameter int PRIO_W   = 8,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 64,
   parameter int IDLE_VEC = 24,
   parameter bit REG_OUT  = 1'b1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_SRC-1:0]        pend_i,
   input logic [NUM_SRC-1:0]        force_i,
   input logic [NUM_SRC-1:0]        en_i,
   input logic [NUM_SRC-1:0]        mask_i,
   input logic [NUM_SRC*PRIO_W-1:0] prio_i,
   input logic [PRIO_W-1:0]         lvl_o,
   input logic [VEC_W-1:0]          vec_o,
   input logic [PRIO_W-1:0]         lvl_q_o,
   input logic [VEC_W-1:0]          vec_q_o
);

   logic [NUM_SRC-1:0] act_c;
   logic               any_act;
   logic               in_rng;
   logic               win_act;
   logic [PRIO_W-1:0]  win_pri;
   logic               better;
   logic               past_ok;
   int                 widx;

   assign act_c   = (pend_i | force_i) & en_i & ~mask_i;
   assign any_act = |act_c;

   always_comb begin
      widx    = int'(vec_o) - VEC_BASE;
      in_rng  = (widx >= 0) && (widx < NUM_SRC);
      win_act = 1'b0;
      win_pri = '0;
      better  = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (i == widx) begin
            win_act = act_c[i];
            win_pri = prio_i[i*PRIO_W +: PRIO_W];
         end
         if (act_c[i] && in_rng &&
             ((prio_i[i*PRIO_W +: PRIO_W] > lvl_o) ||
              ((prio_i[i*PRIO_W +: PRIO_W] == lvl_o) && (i > widx))))
            better = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R6
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_act |-> (lvl_o == '0) && (vec_o == VEC_W'(IDLE_VEC)));

   // R4
   vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |-> in_rng);

   // R1
   win_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |-> win_act);

   // R5
   lvl_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |-> (lvl_o == win_pri));

   // R2 R3
   no_better_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |-> !better);

   if (REG_OUT) begin : g_reg_chk
      // R8
      reg_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok |-> (lvl_q_o == $past(lvl_o)) && (vec_q_o == $past(vec_o)));
   end

endmodule

bind irq_vec_resolver irq_res_chk #(
   .NUM_SRC  (NUM_SRC),
   .PRIO_W   (PRIO_W),
   .VEC_W    (VEC_W),
   .VEC_BASE (VEC_BASE),
   .IDLE_VEC (IDLE_VEC),
   .REG_OUT  (REG_OUT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pend_i  (pend_i),
   .force_i (force_i),
   .en_i    (en_i),
   .mask_i  (mask_i),
   .prio_i  (prio_i),
   .lvl_o   (lvl_o),
   .vec_o   (vec_o),
   .lvl_q_o (lvl_q_o),
   .vec_q_o (vec_q_o)
);

// File: tb/sim_irq_vec_resolver.sv
`timescale 1ns/1ps
module sim_irq_vec_resolver;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [63:0]  pend = '0, frc = '0, en = '0, msk = '0;
   logic [511:0] prio = '0;
   logic [7:0]   lvl, vec, lvl_q, vec_q;
   int           total = 0, bad = 0;
   bit           done = 1'b0;

   always #4 clk = ~clk;

   irq_vec_resolver u0 (
      .clk (clk), .rst_n (rst_n),
      .pend_i (pend), .force_i (frc), .en_i (en), .mask_i (msk),
      .prio_i (prio),
      .lvl_o (lvl), .vec_o (vec), .lvl_q_o (lvl_q), .vec_q_o (vec_q)
   );

   typedef struct packed {
      logic [63:0] p, f, e, m;
      logic [1:0]  mode;
      logic [7:0]  seed;
      logic [7:0]  xl, xv;
      logic [3:0]  req;
   } vec_t;

   localparam logic [63:0] ONES = '1;

   // mode 0: every byte = seed, 1: byte i = i, 2: byte i = 63 - i
   localparam vec_t TBL [13] = '{
      '{64'h0, 64'h0, ONES, 64'h0, 2'd0, 8'd5, 8'd0, 8'd24, 4'd6},               // R6 nothing pending
      '{64'h8, 64'h0, ONES, 64'h0, 2'd0, 8'd7, 8'd7, 8'd67, 4'd4},               // R4 single source 3
      '{ONES, 64'h0, ONES, 64'h0, 2'd0, 8'd9, 8'd9, 8'd127, 4'd3},               // R3 full tie
      '{ONES, 64'h0, ONES, ONES, 2'd0, 8'd9, 8'd0, 8'd24, 4'd1},                 // R1 all masked
      '{64'h0, 64'h400, ONES, 64'h0, 2'd1, 8'd0, 8'd10, 8'd74, 4'd1},            // R1 force only
      '{64'h400, 64'h0, 64'hFFFF_FFFF_FFFF_FBFF, 64'h0, 2'd1, 8'd0, 8'd0, 8'd24, 4'd1}, // R1 disabled
      '{ONES, 64'h0, ONES, 64'h0, 2'd2, 8'd0, 8'd63, 8'd64, 4'd2},               // R2 descending
      '{ONES, 64'h0, ONES, 64'h0, 2'd1, 8'd0, 8'd63, 8'd127, 4'd2},              // R2 ascending
      '{64'h0000_0100_0000_0020, 64'h0, ONES, 64'h0, 2'd0, 8'd0, 8'd0, 8'd104, 4'd7}, // R7 zero level
      '{64'h0004_0000_0010_0000, 64'h0, ONES, 64'h0004_0000_0000_0000, 2'd1, 8'd0, 8'd20, 8'd84, 4'd1}, // R1 mask winner
      '{64'h1, 64'h0, ONES, 64'h0, 2'd0, 8'd255, 8'd255, 8'd64, 4'd5},           // R5 full byte
      '{64'h8000_0000_0000_0001, 64'h0, ONES, 64'h0, 2'd2, 8'd0, 8'd63, 8'd64, 4'd2}, // R2 ends
      '{64'h208, 64'h4000_0000, ONES, 64'h0, 2'd0, 8'd4, 8'd4, 8'd94, 4'd3}      // R3 subset tie
   };

   function automatic logic [511:0] mk_prio(input logic [1:0] mode, input logic [7:0] seed);
      logic [511:0] r;
      for (int i = 0; i < 64; i++) begin
         case (mode)
            2'd0:    r[i*8 +: 8] = seed;
            2'd1:    r[i*8 +: 8] = 8'(i);
            2'd2:    r[i*8 +: 8] = 8'(63 - i);
            default: r[i*8 +: 8] = 8'($urandom_range(0, 255));
         endcase
      end
      return r;
   endfunction

   // serial upward scan with greater-or-equal
   task automatic ref_model(output logic [7:0] el, output logic [7:0] ev);
      int best;
      int bl;
      best = 64;
      bl   = 0;
      for (int i = 0; i < 64; i++) begin
         if (((pend[i] | frc[i]) & en[i] & ~msk[i]) && (int'(prio[i*8 +: 8]) >= bl)) begin
            bl   = int'(prio[i*8 +: 8]);
            best = i;
         end
      end
      el = 8'(bl);
      ev = (best == 64) ? 8'd24 : 8'(best + 64);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      logic [7:0] pl, pv, el, ev;
      // reset: registered copy idle, comb path live (R8, R9)
      pend = ONES; en = ONES; prio = mk_prio(2'd0, 8'd9);
      repeat (2) @(negedge clk);
      chk("R8", "reset lvl_q", lvl_q, 8'd0);
      chk("R8", "reset vec_q", vec_q, 8'd24);
      chk("R9", "comb lvl in reset", lvl, 8'd9);
      chk("R9", "comb vec in reset", vec, 8'd127);
      rst_n = 1'b1;
      @(negedge clk);
      pl = 8'd9; pv = 8'd127;

      foreach (TBL[t]) begin
         pend = TBL[t].p; frc = TBL[t].f; en = TBL[t].e; msk = TBL[t].m;
         prio = mk_prio(TBL[t].mode, TBL[t].seed);
         #1;
         chk($sformatf("R%0d", TBL[t].req), $sformatf("table %0d lvl", t), lvl, TBL[t].xl);
         chk($sformatf("R%0d", TBL[t].req), $sformatf("table %0d vec", t), vec, TBL[t].xv);
         chk("R8", "hold before edge lvl_q", lvl_q, pl);
         chk("R8", "hold before edge vec_q", vec_q, pv);
         @(negedge clk);
         chk("R8", "after edge lvl_q", lvl_q, TBL[t].xl);
         chk("R8", "after edge vec_q", vec_q, TBL[t].xv);
         pl = TBL[t].xl; pv = TBL[t].xv;
      end

      // random patterns against the scan model (R1 R2 R3 R4 R5 R6 R7)
      for (int it = 0; it < 300; it++) begin
         pend = {$urandom, $urandom};
         if (it % 3 == 0) pend = pend & {$urandom, $urandom} & {$urandom, $urandom};
         frc  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         en   = ~({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
         msk  = {$urandom, $urandom} & {$urandom, $urandom};
         if (it % 5 == 0) begin pend = '0; frc = '0; end
         if (it % 7 == 0) prio = '0;
         else if (it % 4 == 0) prio = mk_prio(2'd0, 8'($urandom_range(0, 255)));
         else prio = mk_prio(2'd3, 8'd0);
         #1;
         ref_model(el, ev);
         chk("R2", $sformatf("random %0d lvl", it), lvl, el);
         chk("R3", $sformatf("random %0d vec", it), vec, ev);
         @(negedge clk);
         chk("R8", $sformatf("random %0d vec_q", it), vec_q, ev);
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R9 watchdog: actual=hung expected=done");
         summary();
         $finish;
      end
   end

endmodule